// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A system watchdog with a small word-addressed register set on a plain synchronous bus. Software programs a 16-bit reload value, picks whether expiry raises an interrupt or a one-cycle system reset pulse, and may place a power-of-two prescaler in front of the down-counter. The count is read back live through a read-only register.

Servicing the watchdog is guarded. The counter reloads only when software writes two fixed key values, in order, to a 16-bit service register. Any other value written there cancels a half-finished sequence. The control register accepts exactly one write after power-on reset and then freezes. An enabled watchdog therefore cannot be switched off, and one left disabled cannot be switched on.

A reset-time parameter can make the block start already running. In that case it uses the largest reload value, all options set, and the control register locked.

Top module: `kwdt_top`

## Requirements
- R1: With START_EN=0, after reset the control word at byte offset 0x4 reads 0, the count at 0x8 reads 0, and wd_irq and wd_sysrst are low.
- R2: The control word holds the reload value in bits 31:16, run in bit 2, reset-select in bit 1 and slow-clock in bit 0, and reads back at offset 0x4. Only a write with all four byte strobes set is accepted.
- R3: The first accepted control write locks the register. Every later control write is ignored, whether the first write left the timer running or stopped.
- R4: An accepted write with run=1 loads the counter from its reload field at that clock edge. With slow=0 the counter then falls by one each clock. Reads of offset 0x8 return the count in bits 15:0, with data valid one cycle after bus_re.
- R5: With slow=1 the counter falls once every 2**PRE_LOG2 clocks (65536 by default). The first step comes 2**PRE_LOG2 clocks after a load.
- R6: Expiry happens on the step where the count is 1, or where the count is 0 and has not yet expired. The counter then holds at 0 and never wraps.
- R7: With reset-select=1, expiry drives wd_sysrst high for exactly one cycle, from the same clock edge at which the count reaches 0.
- R8: With reset-select=0, expiry raises wd_irq and holds it until the next service reload. wd_sysrst stays low.
- R9: A service write is a write to offset 0xC with byte strobes 1:0 both set; the key is bits 15:0. Writing 0x556C and then 0xAA39 reloads the counter from the reload field at the second write and clears the expiry. A write to 0xC without both low strobes does not change the key sequence.
- R10: 0xAA39 with no 0x556C directly before it does not reload. Any other value cancels a pending sequence. A repeated 0x556C re-arms the sequence.
- R11: Reads of any offset other than 0x4 and 0x8 return 0, and so do reads at addresses that are not word-aligned. A write to the count register has no effect.
- R12: With START_EN=1 the block leaves reset running, with control word 0xFFFF0007 and count 0xFFFF. The register is already locked.
- R13: A reload value of 0 expires on the first counter step after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_addr | input | ADDR_W | Byte address within the 0x100-byte window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte strobes for bus_wdata |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; data appears the next cycle |
| bus_rdata | output | 32 | Registered read data, 0 when no read was made |
| wd_irq | output | 1 | Expiry interrupt level (reset-select=0) |
| wd_sysrst | output | 1 | Expiry reset pulse, one cycle (reset-select=1) |

## Verification
The bench attacks the key checker with a lone second key, a sequence broken by a stray value, a doubled first key and a strobe-deficient write inside a sequence. A checker that reloads too eagerly or forgets its armed state would return a fresh count where the bench expects a decayed one. It tries to re-program the control register after both an enabling and a disabling first write, and after a partial-strobe write that must not lock. A lock that is missing or too eager shows up in the read-back word or in a count that jumps. Expiry timing is pinned to the exact edge for a normal count, for a zero reload and under the prescaler. This catches off-by-one dividers, a counter that wraps past zero, a reset pulse longer than one cycle, and an interrupt that drops before it is serviced.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // Service keys, required in this order
  localparam logic [15:0] KEY_ARM  = 16'h556C;
  localparam logic [15:0] KEY_FIRE = 16'hAA39;

  // Word indices within the register window (byte offset / 4)
  localparam int IX_CTRL  = 1;
  localparam int IX_COUNT = 2;
  localparam int IX_SVC   = 3;

  localparam int CNT_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic             run;
    logic             rst_sel;
    logic             slow;
  } ctrl_t;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int   ADDR_W   = 8,
  parameter logic START_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic              ctrl_load_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic              svc_wr_o,
  output logic [15:0]       svc_key_o
);
  localparam int WIX_W = ADDR_W - 2;
  localparam logic [WIX_W-1:0] W_CTRL  = WIX_W'(IX_CTRL);
  localparam logic [WIX_W-1:0] W_COUNT = WIX_W'(IX_COUNT);
  localparam logic [WIX_W-1:0] W_SVC   = WIX_W'(IX_SVC);
  localparam ctrl_t CTRL_INIT = START_EN ? ctrl_t'({{CNT_W{1'b1}}, 3'b111}) : ctrl_t'('0);

  logic [WIX_W-1:0] widx;
  logic             aligned;
  logic             ctrl_wr;
  ctrl_t            ctrl_q;
  logic             lock_q;
  logic [31:0]      rd_mux;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign ctrl_wr = bus_we && aligned && (widx == W_CTRL) && (bus_be == 4'hF);

  assign ctrl_load_o  = ctrl_wr && !lock_q && bus_wdata[2];
  assign reload_val_o = ctrl_load_o ? bus_wdata[31:16] : ctrl_q.reload;
  assign svc_wr_o     = bus_we && aligned && (widx == W_SVC) && (bus_be[1:0] == 2'b11);
  assign svc_key_o    = bus_wdata[15:0];
  assign ctrl_o       = ctrl_q;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx == W_CTRL)
        rd_mux = {ctrl_q.reload, 13'd0, ctrl_q.run, ctrl_q.rst_sel, ctrl_q.slow};
      else if (widx == W_COUNT)
        rd_mux = {{(32-CNT_W){1'b0}}, cnt_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_INIT;
      lock_q    <= START_EN;
      bus_rdata <= '0;
    end else begin
      if (ctrl_wr && !lock_q) begin
        ctrl_q <= '{reload: bus_wdata[31:16], run: bus_wdata[2],
                    rst_sel: bus_wdata[1], slow: bus_wdata[0]};
        lock_q <= 1'b1;
      end
      bus_rdata <= bus_re ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_key,
  output logic        reload_o
);
  seq_e state_q;

  assign reload_o = svc_wr && (state_q == SEQ_ARMED) && (svc_key == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else if (svc_wr) begin
      state_q <= (svc_key == KEY_ARM) ? SEQ_ARMED : SEQ_IDLE;
    end
  end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int PRE_LOG2 = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic clear,
  output logic tick
);
  generate
    if (PRE_LOG2 > 0) begin : g_div
      logic [PRE_LOG2-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          div_q <= '0;
        else if (clear || !run || !slow)
          div_q <= '0;
        else
          div_q <= div_q + 1'b1;
      end
      assign tick = run && (!slow || (&div_q));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter logic START_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             rst_sel,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sysrst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= START_EN ? {CNT_W{1'b1}} : '0;
      expired_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (load) begin
        cnt_q     <= reload_val;
        expired_q <= 1'b0;
      end else if (tick && !expired_q && (cnt_q <= CNT_W'(1))) begin
        cnt_q     <= '0;
        expired_q <= 1'b1;
        pulse_q   <= rst_sel;
      end else if (tick && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign irq_o    = expired_q && !rst_sel;
  assign sysrst_o = pulse_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int   ADDR_W   = 8,
  parameter int   PRE_LOG2 = 16,
  parameter logic START_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              wd_irq,
  output logic              wd_sysrst
);
  ctrl_t            ctrl_s;
  logic             ctrl_load_s;
  logic [CNT_W-1:0] reload_val_s;
  logic             svc_wr_s;
  logic [15:0]      svc_key_s;
  logic             key_ok_s;
  logic             load_s;
  logic             tick_s;
  logic [CNT_W-1:0] cnt_s;

  kwdt_regs #(.ADDR_W(ADDR_W), .START_EN(START_EN)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cnt_i(cnt_s), .ctrl_o(ctrl_s), .ctrl_load_o(ctrl_load_s),
    .reload_val_o(reload_val_s), .svc_wr_o(svc_wr_s), .svc_key_o(svc_key_s)
  );

  kwdt_keyseq keyseq_i (
    .clk(clk), .rst_n(rst_n),
    .svc_wr(svc_wr_s), .svc_key(svc_key_s), .reload_o(key_ok_s)
  );

  assign load_s = ctrl_load_s || (key_ok_s && ctrl_s.run);

  kwdt_prescale #(.PRE_LOG2(PRE_LOG2)) pre_i (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_s.run), .slow(ctrl_s.slow), .clear(load_s), .tick(tick_s)
  );

  kwdt_core #(.START_EN(START_EN)) core_i (
    .clk(clk), .rst_n(rst_n),
    .load(load_s), .reload_val(reload_val_s), .tick(tick_s),
    .rst_sel(ctrl_s.rst_sel), .cnt_o(cnt_s),
    .irq_o(wd_irq), .sysrst_o(wd_sysrst)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wd_irq,
  input logic        wd_sysrst,
  input logic [15:0] cnt,
  input logic        load,
  input logic [18:0] ctrl
);
  logic [18:0] prev_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= ctrl;
      if (ctrl != prev_q) seen_q <= 1'b1;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_sysrst |=> !wd_sysrst);

  a_r8_irq_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> !wd_sysrst);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq && !load) |=> wd_irq);

  a_r6_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == 16'd0) && !load) |=> (cnt == 16'd0));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - 16'd1)));

  a_r3_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(ctrl));
endmodule

bind kwdt_top kwdt_checker chk_i (
  .clk(clk), .rst_n(rst_n), .wd_irq(wd_irq), .wd_sysrst(wd_sysrst),
  .cnt(cnt_s), .load(load_s), .ctrl(ctrl_s)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, rst_a, irq_b, rst_b;
  logic [31:0] rd_a, rd_b;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  kwdt_top #(.ADDR_W(8), .PRE_LOG2(4), .START_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(rdata_a), .wd_irq(irq_a), .wd_sysrst(rst_a));

  kwdt_top #(.ADDR_W(8), .PRE_LOG2(4), .START_EN(1'b1)) dut_se_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(rdata_b), .wd_irq(irq_b), .wd_sysrst(rst_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge; each uses one rising edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic svc(input logic [15:0] key, input logic [3:0] be);
    wr(8'h0C, {16'h0, key}, be);
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    rd_a = rdata_a; rd_b = rdata_b;
    bus_re = 1'b0;
  endtask

  task automatic por();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic t_start_enabled();
    rd(8'h04); chk("R12 preset control", rd_b, 32'hFFFF0007);
    rd(8'h08); chk("R12 preset count", rd_b, 32'h0000FFFF);
    wr(8'h04, 32'h0000_0000, 4'hF);
    rd(8'h04); chk("R12 preset locked", rd_b, 32'hFFFF0007);
    chk("R12 no expiry yet", {30'd0, irq_b, rst_b}, 32'd0);
  endtask

  task automatic t_reset_state();
    por();
    chk("R1 irq low", {31'd0, irq_a}, 32'd0);
    chk("R1 sysrst low", {31'd0, rst_a}, 32'd0);
    rd(8'h04); chk("R1 control zero", rd_a, 32'd0);
    rd(8'h08); chk("R1 count zero", rd_a, 32'd0);
  endtask

  task automatic t_expire_reset();
    int pulses;
    por();
    wr(8'h04, 32'h000A_0006, 4'hF);            // reload 10, run, reset-select
    rd(8'h08); chk("R4 loaded count", rd_a, 32'd10);
    rd(8'h08); chk("R4 one step per clock", rd_a, 32'd9);
    idle(7);   chk("R7 no pulse before expiry", {31'd0, rst_a}, 32'd0);
    idle(1);   chk("R7 pulse at expiry edge", {31'd0, rst_a}, 32'd1);
    idle(1);   chk("R7 pulse lasts one cycle", {31'd0, rst_a}, 32'd0);
    rd(8'h08); chk("R6 count at zero", rd_a, 32'd0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      idle(1);
      if (rst_a) pulses++;
    end
    chk("R6 no repeat pulse", pulses, 0);
    rd(8'h08); chk("R6 no wrap", rd_a, 32'd0);
    chk("R7 irq stays low", {31'd0, irq_a}, 32'd0);
  endtask

  task automatic t_expire_irq();
    int pulses;
    por();
    wr(8'h04, 32'h0005_0004, 4'hF);            // reload 5, run, interrupt
    idle(4); chk("R8 irq low before expiry", {31'd0, irq_a}, 32'd0);
    idle(1); chk("R8 irq rises at expiry", {31'd0, irq_a}, 32'd1);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      idle(1);
      if (rst_a) pulses++;
    end
    chk("R8 irq held", {31'd0, irq_a}, 32'd1);
    chk("R8 no reset pulse", pulses, 0);
    svc(16'h556C, 4'h3);
    chk("R8 irq held after first key", {31'd0, irq_a}, 32'd1);
    svc(16'hAA39, 4'h3);
    chk("R9 service clears irq", {31'd0, irq_a}, 32'd0);
    rd(8'h08); chk("R9 service reloads", rd_a, 32'd5);
  endtask

  task automatic t_key_order();
    por();
    wr(8'h04, 32'h0014_0006, 4'hF);            // reload 20
    svc(16'hAA39, 4'h3);
    rd(8'h08); chk("R10 lone second key ignored", rd_a, 32'd19);
    svc(16'h556C, 4'h3);
    svc(16'h1234, 4'h3);
    svc(16'hAA39, 4'h3);
    rd(8'h08); chk("R10 stray value cancels", rd_a, 32'd15);
    svc(16'h556C, 4'h3);
    svc(16'h556C, 4'h3);
    svc(16'hAA39, 4'h3);
    rd(8'h08); chk("R10 repeated first key re-arms", rd_a, 32'd20);
    svc(16'h556C, 4'h3);
    svc(16'hAA39, 4'hC);                       // low strobes missing
    rd(8'h08); chk("R9 partial strobe not a service", rd_a, 32'd17);
    svc(16'hAA39, 4'h3);
    rd(8'h08); chk("R9 sequence kept armed", rd_a, 32'd20);
  endtask

  task automatic t_lock_running();
    por();
    wr(8'h04, 32'h0064_0004, 4'hF);            // reload 100, run
    wr(8'h04, 32'h0002_0000, 4'hF);            // attempt to stop
    rd(8'h08); chk("R3 running timer not reloaded", rd_a, 32'd99);
    rd(8'h04); chk("R3 control kept", rd_a, 32'h0064_0004);
  endtask

  task automatic t_lock_stopped();
    por();
    wr(8'h04, 32'h0003_0002, 4'hF);            // stopped, reset-select
    wr(8'h04, 32'h0003_0006, 4'hF);            // attempt to start
    rd(8'h04); chk("R3 stopped stays stopped", rd_a, 32'h0003_0002);
    idle(10);
    chk("R3 no expiry when stopped", {30'd0, irq_a, rst_a}, 32'd0);
    rd(8'h08); chk("R3 count idle", rd_a, 32'd0);
  endtask

  task automatic t_prescale();
    por();
    wr(8'h04, 32'h0003_0007, 4'hF);            // reload 3, slow, reset-select
    rd(8'h08); chk("R5 loaded", rd_a, 32'd3);
    idle(15);
    rd(8'h08); chk("R5 first step after 16 clocks", rd_a, 32'd2);
    idle(30); chk("R5 no pulse before edge 48", {31'd0, rst_a}, 32'd0);
    idle(1);  chk("R5 pulse at edge 48", {31'd0, rst_a}, 32'd1);
  endtask

  task automatic t_zero_reload();
    por();
    wr(8'h04, 32'h0000_0006, 4'hF);
    idle(1); chk("R13 zero reload expires at first step", {31'd0, rst_a}, 32'd1);
    idle(1); chk("R13 single pulse", {31'd0, rst_a}, 32'd0);
  endtask

  task automatic t_bus_map();
    por();
    wr(8'h04, 32'h0005_0006, 4'h3);            // partial strobes
    rd(8'h04); chk("R2 partial write ignored", rd_a, 32'd0);
    wr(8'h08, 32'h0000_1234, 4'hF);
    rd(8'h08); chk("R11 count not writable", rd_a, 32'd0);
    rd(8'h00); chk("R11 offset 0x0 reads zero", rd_a, 32'd0);
    rd(8'h0C); chk("R11 service reads zero", rd_a, 32'd0);
    rd(8'hFC); chk("R11 offset 0xFC reads zero", rd_a, 32'd0);
    wr(8'h04, 32'h0005_0003, 4'hF);            // not locked by partial write
    rd(8'h04); chk("R2 full write accepted", rd_a, 32'h0005_0003);
    rd(8'h06); chk("R11 misaligned reads zero", rd_a, 32'd0);
    idle(1);  chk("R11 idle read data zero", rdata_a, 32'd0);
  endtask

  initial begin
    por();
    t_start_enabled();
    t_reset_state();
    t_expire_reset();
    t_expire_irq();
    t_key_order();
    t_lock_running();
    t_lock_stopped();
    t_prescale();
    t_zero_reload();
    t_bus_map();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: bench did not complete");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule